// File: doc/BRIEF.md
# Four-Slot Transmit Descriptor Engine

This block moves outgoing frames from system memory to a MAC. Software owns four fixed descriptor slots. Each slot holds a 32-bit buffer base address and a 32-bit status/command word. To hand a frame over, software writes the base address first and then the status word. The status word carries the frame length and a start threshold, and writing it passes ownership of the slot to the engine.

The engine visits the slots in a fixed rotation and waits on the current slot even when a later one is ready. It fetches the frame one byte per read from a byte-addressable memory, where read data returns one cycle after the request, and buffers the bytes in a small FIFO. It streams them to the MAC over a valid/ready byte interface. When the last byte is accepted, it writes a result into the slot's status word, hands the slot back to software and raises a sticky interrupt status flag. Frames are sent exactly as stored: no padding is added and no FCS is generated.

Top module: `txd_engine`

## Requirements
- R1: After reset, every slot status word reads 0x0000_2000 (host-owns bit 13 set, all other bits 0). Every slot address register and the interrupt status word (offset 0x3C) read 0, and `tx_valid` is low.
- R2: The slot status words are at offsets 0x10/0x14/0x18/0x1C and the address registers at 0x20/0x24/0x28/0x2C. A status write keeps only the length (bits 12:0) and the threshold (bits 21:16), clears every other bit including host-owns, and queues the slot. Address registers read back as written.
- R3: Slots are served in the strict order 0,1,2,3,0,... A queued slot that is not the current one issues no memory read and produces no output until every slot ahead of it in the rotation has completed.
- R4: A frame of length L at base B is output as the bytes at B, B+1, ..., B+L-1, in that order. `tx_last` is high only with the final byte. While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R5: Output of a frame starts only after min(threshold*32, L, FIFO_DEPTH) of its bytes have been fetched. Threshold 0 allows output as soon as the first byte is buffered.
- R6: A good frame completes on the acceptance of its last byte. At that point the slot status has bit 13 (host-owns) and bit 15 (transmit OK) set in addition to the stored fields, and interrupt status bit 2 is set.
- R7: A length of 0 or above 1792 completes without any memory read or output. The slot status then has bit 13 and bit 30 (aborted) set in addition to the stored fields, and interrupt status bit 3 is set. A length of exactly 1792 is sent normally.
- R8: Writing the interrupt status word clears each bit written as 1 and leaves each bit written as 0 unchanged. A flag raised in the same cycle stays set.
- R9: A status write to a slot whose host-owns bit is clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for a write or a read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| mem_rd | output | 1 | Memory byte read request |
| mem_addr | output | 32 | Memory byte address |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_rd` |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | MAC accepts the byte |

## Verification
The bench queues a slot out of turn and also rewrites a slot it has already queued. An engine that skipped ahead in the rotation would send the wrong frame first, and one that accepted the rewrite would change the frame length mid-queue. With the sink stalled, the bench counts the memory reads that happen before the first valid byte, using both a small threshold and a threshold larger than the frame. An engine that ignored the threshold, or waited for a FIFO-sized count that a short frame never reaches, would start too early or never start. Lengths 0, 1793 and 1792 probe the abort boundary. Writes of 0 and of the other flag's bit to the interrupt word would expose a clear that does not honour the per-bit mask.

// File: rtl/txd_pkg.sv
package txd_pkg;
    localparam int NSLOT      = 4;
    localparam int SLOT_W     = $clog2(NSLOT);
    localparam int REG_AW     = 8;
    localparam int LEN_W      = 13;
    localparam int THR_W      = 6;
    localparam int THR_LSB    = 16;
    localparam int UNIT_SHIFT = 5;
    localparam int BIT_OWN    = 13;
    localparam int BIT_OK     = 15;
    localparam int BIT_ABORT  = 30;
    localparam int IRQ_OK_BIT  = 2;
    localparam int IRQ_ERR_BIT = 3;

    localparam logic [LEN_W-1:0]  MAX_LEN    = 13'd1792;
    localparam logic [REG_AW-1:0] STAT_BASE  = 8'h10;
    localparam logic [REG_AW-1:0] ADDR_BASE  = 8'h20;
    localparam logic [REG_AW-1:0] IRQ_OFS    = 8'h3C;
    localparam logic [31:0]       FIELD_MASK = 32'h003F_1FFF;

    typedef struct packed {
        logic [31:0]      base;
        logic [LEN_W-1:0] len;
        logic [THR_W-1:0] thr;
    } job_t;

    typedef struct packed {
        logic              valid;
        logic              ok;
        logic [SLOT_W-1:0] slot;
    } done_t;

    function automatic logic len_bad(input logic [LEN_W-1:0] len);
        return (len == '0) || (len > MAX_LEN);
    endfunction

    // Bytes that must be buffered before output may begin.
    function automatic logic [LEN_W-1:0] start_count(input logic [THR_W-1:0] thr,
                                                     input logic [LEN_W-1:0] len,
                                                     input logic [LEN_W-1:0] depth);
        logic [LEN_W-1:0] t;
        t = LEN_W'(thr) << UNIT_SHIFT;
        if (len < t)   t = len;
        if (depth < t) t = depth;
        return t;
    endfunction
endpackage

// File: rtl/txd_slots.sv
module txd_slots
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [SLOT_W-1:0] sel,
    output job_t              sel_job,
    output logic              sel_own,
    input  done_t             done,
    output logic              irq_ok,
    output logic              irq_err
);
    logic [31:0] stat_q [NSLOT];
    logic [31:0] addr_q [NSLOT];

    for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
        localparam logic [REG_AW-1:0] S_OFS = STAT_BASE + REG_AW'(4 * gi);
        localparam logic [REG_AW-1:0] A_OFS = ADDR_BASE + REG_AW'(4 * gi);
        logic fin;
        assign fin = done.valid && (done.slot == SLOT_W'(gi));

        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[gi] <= 32'(1) << BIT_OWN;
                addr_q[gi] <= '0;
            end else begin
                if (reg_we && reg_addr == A_OFS)
                    addr_q[gi] <= reg_wdata;
                if (fin)
                    stat_q[gi] <= stat_q[gi] | (32'(1) << BIT_OWN)
                                 | (done.ok ? (32'(1) << BIT_OK) : (32'(1) << BIT_ABORT));
                else if (reg_we && reg_addr == S_OFS && stat_q[gi][BIT_OWN])
                    stat_q[gi] <= reg_wdata & FIELD_MASK;
            end
        end
    end

    logic w1c;
    assign w1c = reg_we && (reg_addr == IRQ_OFS);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_ok  <= 1'b0;
            irq_err <= 1'b0;
        end else begin
            irq_ok  <= (irq_ok  & ~(w1c & reg_wdata[IRQ_OK_BIT]))  | (done.valid &  done.ok);
            irq_err <= (irq_err & ~(w1c & reg_wdata[IRQ_ERR_BIT])) | (done.valid & ~done.ok);
        end
    end

    always_comb begin
        sel_job.base = addr_q[sel];
        sel_job.len  = stat_q[sel][LEN_W-1:0];
        sel_job.thr  = stat_q[sel][THR_LSB +: THR_W];
        sel_own      = stat_q[sel][BIT_OWN];
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (reg_addr == STAT_BASE + REG_AW'(4 * i)) reg_rdata = stat_q[i];
            if (reg_addr == ADDR_BASE + REG_AW'(4 * i)) reg_rdata = addr_q[i];
        end
        if (reg_addr == IRQ_OFS) begin
            reg_rdata[IRQ_OK_BIT]  = irq_ok;
            reg_rdata[IRQ_ERR_BIT] = irq_err;
        end
    end
endmodule

// File: rtl/txd_fifo.sv
module txd_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic [AW:0]  count,
    output logic         empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    assign dout  = mem[rp];
    assign empty = (count == '0);

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            count <= count + (AW+1)'(push) - (AW+1)'(pop);
        end
    end
endmodule

// File: rtl/txd_ctl.sv
module txd_ctl
    import txd_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  job_t              cur_job,
    input  logic              cur_own,
    output logic [SLOT_W-1:0] cur_slot,
    input  logic [AW:0]       fifo_count,
    input  logic              fifo_empty,
    output logic              push,
    output logic              pop,
    output logic              mem_rd,
    output logic [31:0]       mem_addr,
    output logic              tx_valid,
    output logic              tx_last,
    input  logic              tx_ready,
    output done_t             done
);
    typedef enum logic {S_IDLE, S_RUN} state_t;

    state_t            state;
    job_t              job_q;
    logic [LEN_W-1:0]  iss_cnt, rcv_cnt, snd_cnt, start_q, rcv_next;
    logic              started, rd_q, space, fire;

    assign space    = ({1'b0, fifo_count} + (AW+2)'(rd_q)) < (AW+2)'(DEPTH);
    assign mem_rd   = (state == S_RUN) && (iss_cnt < job_q.len) && space;
    assign mem_addr = job_q.base + 32'(iss_cnt);
    assign push     = rd_q;
    assign tx_valid = (state == S_RUN) && started && !fifo_empty;
    assign tx_last  = (snd_cnt == job_q.len - LEN_W'(1));
    assign fire     = tx_valid && tx_ready;
    assign pop      = fire;
    assign rcv_next = rcv_cnt + LEN_W'(rd_q);
    assign cur_slot = done.slot;

    always_comb begin
        done.ok    = (state == S_RUN);
        done.valid = ((state == S_IDLE) && !cur_own && len_bad(cur_job.len))
                   || (fire && tx_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            done.slot <= '0;
            job_q     <= '0;
            iss_cnt   <= '0;
            rcv_cnt   <= '0;
            snd_cnt   <= '0;
            start_q   <= '0;
            started   <= 1'b0;
            rd_q      <= 1'b0;
        end else begin
            rd_q <= mem_rd;
            case (state)
                S_IDLE: begin
                    if (!cur_own) begin
                        if (len_bad(cur_job.len)) begin
                            done.slot <= done.slot + 1'b1;
                        end else begin
                            job_q   <= cur_job;
                            iss_cnt <= '0;
                            rcv_cnt <= '0;
                            snd_cnt <= '0;
                            started <= 1'b0;
                            start_q <= start_count(cur_job.thr, cur_job.len, LEN_W'(DEPTH));
                            state   <= S_RUN;
                        end
                    end
                end
                S_RUN: begin
                    iss_cnt <= iss_cnt + LEN_W'(mem_rd);
                    rcv_cnt <= rcv_next;
                    if (rcv_next >= start_q) started <= 1'b1;
                    if (fire) snd_cnt <= snd_cnt + 1'b1;
                    if (fire && tx_last) begin
                        state     <= S_IDLE;
                        started   <= 1'b0;
                        done.slot <= done.slot + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txd_engine.sv
module txd_engine
    import txd_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    localparam int FAW       = $clog2(FIFO_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_rd,
    output logic [31:0]       mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);
    job_t              cur_job;
    logic              cur_own;
    logic [SLOT_W-1:0] cur_slot;
    done_t             done;
    logic              irq_ok, irq_err;
    logic              push, pop, fifo_empty;
    logic [FAW:0]      fifo_count;
    logic              done_vld, done_ok;
    logic [SLOT_W-1:0] done_slot;

    assign done_vld  = done.valid;
    assign done_ok   = done.ok;
    assign done_slot = done.slot;

    txd_slots u_slots (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sel(cur_slot), .sel_job(cur_job), .sel_own(cur_own),
        .done(done), .irq_ok(irq_ok), .irq_err(irq_err)
    );

    txd_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(push), .din(mem_rdata), .pop(pop), .dout(tx_data),
        .count(fifo_count), .empty(fifo_empty)
    );

    txd_ctl #(.DEPTH(FIFO_DEPTH)) u_ctl (
        .clk(clk), .rst(rst),
        .cur_job(cur_job), .cur_own(cur_own), .cur_slot(cur_slot),
        .fifo_count(fifo_count), .fifo_empty(fifo_empty),
        .push(push), .pop(pop),
        .mem_rd(mem_rd), .mem_addr(mem_addr),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .done(done)
    );
endmodule

// File: rtl/txd_engine_chk.sv
module txd_engine_chk
    import txd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              mem_rd,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_last,
    input logic              done_vld,
    input logic              done_ok,
    input logic [SLOT_W-1:0] done_slot,
    input logic              irq_ok,
    input logic              irq_err
);
    logic [SLOT_W-1:0] turn;

    always_ff @(posedge clk) begin
        if (rst)           turn <= '0;
        else if (done_vld) turn <= turn + 1'b1;
    end

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R4

    AST_ROTATION_ORDER: assert property (@(posedge clk) disable iff (rst)
        done_vld |-> (done_slot == turn)); // R3

    AST_OK_FLAG_RAISED: assert property (@(posedge clk) disable iff (rst)
        (done_vld && done_ok) |=> irq_ok); // R6

    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (done_vld && !done_ok) |-> (!tx_valid && !mem_rd)); // R7

    AST_ERR_FLAG_RAISED: assert property (@(posedge clk) disable iff (rst)
        (done_vld && !done_ok) |=> irq_err); // R7

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == IRQ_OFS && reg_wdata[IRQ_OK_BIT] && !(done_vld && done_ok))
        |=> !irq_ok); // R8
endmodule

bind txd_engine txd_engine_chk u_chk (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_rd(mem_rd),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .done_vld(done_vld), .done_ok(done_ok), .done_slot(done_slot),
    .irq_ok(irq_ok), .irq_err(irq_err)
);

// File: tb/txd_engine_test.sv
module txd_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int served = 0;
    int rx_n = 0;
    int last_cnt = 0;
    int last_idx = 0;
    logic [7:0] rx_mem [4096];

    always #10 clk = ~clk;

    txd_engine uut (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= pat(mem_addr);
            served    <= served + 1;
        end
    end

    always @(posedge clk) begin
        if (tx_valid && tx_ready) begin
            rx_mem[rx_n % 4096] <= tx_data;
            rx_n <= rx_n + 1;
            if (tx_last) begin
                last_cnt <= last_cnt + 1;
                last_idx <= rx_n;
            end
        end
    end

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_rx(input int target, input bit toggle);
        int cyc = 0;
        while (rx_n < target && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (toggle) tx_ready = (cyc % 3 != 0);
        end
        tx_ready = 1'b1;
        @(negedge clk);
    endtask

    task automatic chk_frame(input string tag, input int first, input logic [31:0] base, input int len);
        int bad = 0;
        int pos = -1;
        for (int i = 0; i < len; i++)
            if (rx_mem[(first + i) % 4096] !== pat(base + 32'(i)) && pos < 0) begin
                bad++; pos = i;
            end
        chk_eq({tag, " byte mismatch position"}, 32'(pos), 32'hFFFF_FFFF);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int s = 0; s < 4; s++) begin
            rd(8'h10 + 8'(4 * s), d); chk_eq("R1 status after reset", d, 32'h0000_2000);
            rd(8'h20 + 8'(4 * s), d); chk_eq("R1 address after reset", d, 32'h0);
        end
        rd(8'h3C, d); chk_eq("R1 irq after reset", d, 32'h0);
        chk_eq("R1 tx_valid after reset", 32'(tx_valid), 32'h0);
    endtask

    task automatic t_basic;
        logic [31:0] d;
        int first = rx_n;
        int lc = last_cnt;
        wr(8'h20, 32'h0000_0100);
        rd(8'h20, d); chk_eq("R2 address readback", d, 32'h0000_0100);
        wr(8'h10, 32'hC0C0_E03C);
        wait_rx(first + 60, 1'b0);
        chk_frame("R4 slot0 frame", first, 32'h100, 60);
        chk_eq("R4 one last marker", 32'(last_cnt - lc), 32'd1);
        chk_eq("R4 last on final byte", 32'(last_idx), 32'(first + 59));
        rd(8'h10, d); chk_eq("R2 R6 slot0 status", d, 32'h0000_A03C);
        rd(8'h3C, d); chk_eq("R6 irq ok flag", d, 32'h4);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        wr(8'h3C, 32'h0);
        rd(8'h3C, d); chk_eq("R8 write 0 keeps flag", d, 32'h4);
        wr(8'h3C, 32'h8);
        rd(8'h3C, d); chk_eq("R8 other bit keeps flag", d, 32'h4);
        wr(8'h3C, 32'h4);
        rd(8'h3C, d); chk_eq("R8 write 1 clears flag", d, 32'h0);
    endtask

    task automatic t_rotation;
        logic [31:0] d;
        int s0, r0, first;
        wr(8'h24, 32'h0000_0400);
        wr(8'h28, 32'h0000_0800);
        wr(8'h18, 32'h0000_0050);
        s0 = served; r0 = rx_n;
        repeat (40) @(negedge clk);
        chk_eq("R3 out-of-turn slot issues no read", 32'(served - s0), 32'h0);
        chk_eq("R3 out-of-turn slot sends nothing", 32'(rx_n - r0), 32'h0);
        wr(8'h18, 32'h0000_0020);
        rd(8'h18, d); chk_eq("R9 rewrite of queued slot ignored", d, 32'h0000_0050);
        first = rx_n;
        wr(8'h14, 32'h0000_0040);
        wait_rx(first + 64 + 80, 1'b0);
        chk_frame("R3 slot1 first", first, 32'h400, 64);
        chk_frame("R3 slot2 second", first + 64, 32'h800, 80);
        rd(8'h18, d); chk_eq("R6 slot2 status", d, 32'h0000_A050);
        first = rx_n;
        wr(8'h2C, 32'h0000_0C00);
        wr(8'h1C, 32'h0000_0046);
        wait_rx(first + 70, 1'b1);
        chk_frame("R3 slot3 frame", first, 32'hC00, 70);
        wr(8'h3C, 32'h4);
    endtask

    task automatic t_thresh(input logic [7:0] slot, input logic [31:0] base, input int len,
                            input int thr, input int lo, input int hi);
        logic [31:0] d;
        logic [7:0] held;
        int s0, first, cyc;
        first = rx_n;
        tx_ready = 1'b0;
        wr(8'h20 + 8'(4 * slot), base);
        s0 = served;
        wr(8'h10 + 8'(4 * slot), (32'(thr) << 16) | 32'(len));
        cyc = 0;
        while (!tx_valid && cyc < 2000) begin @(negedge clk); cyc++; end
        chk_rng("R5 bytes fetched before first valid", served - s0, lo, hi);
        held = tx_data;
        repeat (3) @(negedge clk);
        chk_eq("R4 data held under stall", 32'(tx_data), 32'(held));
        chk_eq("R4 first byte value", 32'(held), 32'(pat(base)));
        wait_rx(first + len, 1'b1);
        chk_frame("R4 R5 threshold frame", first, base, len);
        rd(8'h10 + 8'(4 * slot), d);
        chk_eq("R6 threshold slot status", d, (32'(thr) << 16) | 32'(len) | 32'h0000_A000);
        wr(8'h3C, 32'h4);
    endtask

    task automatic t_bad(input logic [7:0] slot, input logic [12:0] len);
        logic [31:0] d;
        int s0 = served;
        int r0 = rx_n;
        wr(8'h10 + 8'(4 * slot), 32'(len));
        repeat (4) @(negedge clk);
        rd(8'h10 + 8'(4 * slot), d);
        chk_eq("R7 aborted status", d, 32'h4000_2000 | 32'(len));
        chk_eq("R7 no memory read", 32'(served - s0), 32'h0);
        chk_eq("R7 no output", 32'(rx_n - r0), 32'h0);
        rd(8'h3C, d); chk_eq("R7 irq err flag", d, 32'h8);
        wr(8'h3C, 32'h8);
        rd(8'h3C, d); chk_eq("R8 err flag cleared", d, 32'h0);
    endtask

    task automatic t_maxlen;
        logic [31:0] d;
        int first = rx_n;
        wr(8'h20, 32'h0000_1000);
        wr(8'h10, 32'h0002_0700);
        wait_rx(first + 1792, 1'b0);
        chk_frame("R7 length 1792 sent", first, 32'h1000, 1792);
        rd(8'h10, d); chk_eq("R7 length 1792 status", d, 32'h0002_A700);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_basic();
        t_irq();
        t_rotation();
        t_thresh(8'd0, 32'h0000_2000, 100, 1, 32, 35);
        t_thresh(8'd1, 32'h0000_3000, 60, 63, 60, 61);
        t_bad(8'd2, 13'd0);
        t_bad(8'd3, 13'd1793);
        t_maxlen();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule